// File: doc/BRIEF.md
# Instruction Class Decoder with Condition Check

This block accepts one 32-bit instruction word per transfer, together with the address the word was fetched from and the four status flags (negative, zero, carry, overflow). It sorts the word into one of four classes: data processing, memory load/store, branch, or unsupported. It pulls out the register and opcode fields and checks the 4-bit condition field against the flags to decide whether the instruction may execute. For branches it also produces the PC-relative target and, when linking is requested, the return address to be written to register 14.

Input and output are valid/ready streams with a single registered stage. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. The decoded result appears one cycle after the word is accepted.

Top module: `dcu_top`

## Requirements
- R1: Bits 27..25 set the class, reported on `out_class`. The pattern 00x gives 0 (data processing), 01x gives 1 (load/store), and 101 gives 2 (branch). The patterns 100 and 11x give 3 (unsupported).
- R2: `out_opcode` is bits 24..21, `out_rn` is bits 19..16 and `out_rd` is bits 15..12. `out_imm_sel` is bit 25 for data processing and 0 for every other class.
- R3: `in_flags` is {N,Z,C,V} (bit 3 down to bit 0). Condition codes 0 to 7 pass on a single flag test: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R4: Code 8 passes on C=1 and Z=0, and code 9 on C=0 or Z=1. Code 10 passes on N==V and code 11 on N!=V. Code 12 passes on Z=0 and N==V, and code 13 on Z=1 or N!=V.
- R5: Condition code 14 always passes and code 15 never passes. `out_exec` is high only when the condition passes and the class is not unsupported.
- R6: `out_target` = address + 8 + (bits 23..0 sign-extended and shifted left by 2). Example: word 0xEAFFFFFB at address 0x00400018 gives 0x0040000C.
- R7: `out_link` is high for an executing branch with bit 24 set. `out_link_addr` = address + 4.
- R8: `out_set_flags` is high only for an executing data-processing word with bit 20 set.
- R9: `out_wr_en` is high for an executing data-processing word whose opcode is not in 8..11, or for an executing load/store word with bit 20 set (load).
- R10: When `out_exec` is low, `out_wr_en`, `out_link` and `out_set_flags` are all low.
- R11: `in_ready` = !`out_valid` || `out_ready`. An accepted word appears on the outputs after the next clock edge. All outputs hold while `out_valid` is high and `out_ready` is low.
- R12: During and after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_instr | input | 32 | Instruction word |
| in_pc | input | ADDR_W | Address of the instruction word |
| in_flags | input | 4 | Status flags {N,Z,C,V} |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 2 | Class code |
| out_opcode | output | 4 | Opcode field |
| out_rn | output | 4 | First operand register |
| out_rd | output | 4 | Destination register |
| out_imm_sel | output | 1 | Immediate second operand (data processing) |
| out_exec | output | 1 | Condition passed and class supported |
| out_wr_en | output | 1 | Destination register write request |
| out_set_flags | output | 1 | Flag update request |
| out_link | output | 1 | Link register write request |
| out_link_addr | output | ADDR_W | Return address |
| out_target | output | ADDR_W | Branch target |

## Verification
A failing condition and a side-effect request can fall in the same word. Examples are a conditional branch-with-link, a conditional load, and a conditional flag-setting move. Such words are driven with flag sets chosen so the condition fails and, separately, so it passes. Write, link and flag update must be suppressed together in the failing case and must follow their class rules in the passing case. A second overlap is a new word arriving while the previous result is stalled. This is provoked by holding `out_ready` low. The test then checks that the stalled result stays intact and that the waiting word is taken in the same cycle the stall is released.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

  typedef enum logic [1:0] {
    CLS_DP    = 2'd0,
    CLS_LS    = 2'd1,
    CLS_BR    = 2'd2,
    CLS_UNSUP = 2'd3
  } insn_class_e;

  typedef struct packed {
    insn_class_e cls;
    logic [3:0]  opcode;
    logic [3:0]  rn;
    logic [3:0]  rd;
    logic        imm_bit;
    logic        s_bit;
    logic        link_bit;
    logic [23:0] offset;
  } dec_fields_t;

  // Evaluate one condition code against flags n, z, c, v.
  function automatic logic cond_holds(input logic [3:0] code,
                                      input logic n, input logic z,
                                      input logic c, input logic v);
    logic res;
    case (code)
      4'd0:    res = z;
      4'd1:    res = !z;
      4'd2:    res = c;
      4'd3:    res = !c;
      4'd4:    res = n;
      4'd5:    res = !n;
      4'd6:    res = v;
      4'd7:    res = !v;
      4'd8:    res = c && !z;
      4'd9:    res = !c || z;
      4'd10:   res = (n == v);
      4'd11:   res = (n != v);
      4'd12:   res = !z && (n == v);
      4'd13:   res = z || (n != v);
      4'd14:   res = 1'b1;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dcu_class_dec.sv
module dcu_class_dec
  import dcu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] instr,
  output dec_fields_t       fields
);
  localparam int CLS_HI = 27;
  localparam int CLS_LO = 25;

  logic [CLS_HI-CLS_LO:0] cls_bits;
  assign cls_bits = instr[CLS_HI:CLS_LO];

  always_comb begin
    fields.opcode   = instr[24:21];
    fields.rn       = instr[19:16];
    fields.rd       = instr[15:12];
    fields.imm_bit  = instr[25];
    fields.s_bit    = instr[20];
    fields.link_bit = instr[24];
    fields.offset   = instr[23:0];
    casez (cls_bits)
      3'b00?:  fields.cls = CLS_DP;
      3'b01?:  fields.cls = CLS_LS;
      3'b101:  fields.cls = CLS_BR;
      default: fields.cls = CLS_UNSUP;
    endcase
  end
endmodule

// File: rtl/dcu_cond_eval.sv
module dcu_cond_eval
  import dcu_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] cond,
  input  logic [3:0]        flags,
  output logic              pass
);
  localparam int N_COND = 1 << COND_W;

  logic [N_COND-1:0] pass_vec;

  for (genvar i = 0; i < N_COND; i++) begin : g_code
    assign pass_vec[i] = cond_holds(4'(i), flags[3], flags[2], flags[1], flags[0]);
  end

  assign pass = pass_vec[cond];
endmodule

// File: rtl/dcu_branch_calc.sv
module dcu_branch_calc #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 24,
  parameter int PIPE_AHEAD = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] link_addr
);
  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

  logic [ADDR_W-1:0] byte_off;

  assign byte_off  = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
  assign target    = pc + ADDR_W'(PIPE_AHEAD) + byte_off;
  assign link_addr = pc + ADDR_W'(WORD_BYTES);
endmodule

// File: rtl/dcu_top.sv
module dcu_top
  import dcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_class,
  output logic [3:0]        out_opcode,
  output logic [3:0]        out_rn,
  output logic [3:0]        out_rd,
  output logic              out_imm_sel,
  output logic              out_exec,
  output logic              out_wr_en,
  output logic              out_set_flags,
  output logic              out_link,
  output logic [ADDR_W-1:0] out_link_addr,
  output logic [ADDR_W-1:0] out_target
);
  localparam int COND_W = 4;
  localparam int COND_LO = 32 - COND_W;

  dec_fields_t       f;
  logic              cond_ok;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] lnk_c;

  dcu_class_dec #(.WORD_W(32)) u_cls (
    .instr  (in_instr),
    .fields (f)
  );

  dcu_cond_eval #(.COND_W(COND_W)) u_cond (
    .cond  (in_instr[31:COND_LO]),
    .flags (in_flags),
    .pass  (cond_ok)
  );

  dcu_branch_calc #(.ADDR_W(ADDR_W), .OFF_W(24), .PIPE_AHEAD(8), .WORD_BYTES(4)) u_br (
    .pc        (in_pc),
    .offset    (f.offset),
    .target    (tgt_c),
    .link_addr (lnk_c)
  );

  logic exec_c, wr_c, setf_c, link_c, imm_c, no_dest;

  always_comb begin
    no_dest = (f.opcode[3:2] == 2'b10);
    exec_c  = cond_ok && (f.cls != CLS_UNSUP);
    wr_c    = exec_c && (((f.cls == CLS_DP) && !no_dest) ||
                         ((f.cls == CLS_LS) && f.s_bit));
    setf_c  = exec_c && (f.cls == CLS_DP) && f.s_bit;
    link_c  = exec_c && (f.cls == CLS_BR) && f.link_bit;
    imm_c   = (f.cls == CLS_DP) && f.imm_bit;
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_class     <= '0;
      out_opcode    <= '0;
      out_rn        <= '0;
      out_rd        <= '0;
      out_imm_sel   <= 1'b0;
      out_exec      <= 1'b0;
      out_wr_en     <= 1'b0;
      out_set_flags <= 1'b0;
      out_link      <= 1'b0;
      out_link_addr <= '0;
      out_target    <= '0;
    end else begin
      if (take) begin
        out_valid     <= 1'b1;
        out_class     <= f.cls;
        out_opcode    <= f.opcode;
        out_rn        <= f.rn;
        out_rd        <= f.rd;
        out_imm_sel   <= imm_c;
        out_exec      <= exec_c;
        out_wr_en     <= wr_c;
        out_set_flags <= setf_c;
        out_link      <= link_c;
        out_link_addr <= lnk_c;
        out_target    <= tgt_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_instr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_class,
  input logic              out_exec,
  input logic              out_wr_en,
  input logic              out_set_flags,
  input logic              out_link,
  input logic [ADDR_W-1:0] out_target
);
  assert_nv_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[31:28] == 4'hF) |=> !out_exec);

  assert_unsup_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd3) |-> !out_exec);

  assert_fail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_exec) |-> !(out_wr_en || out_link || out_set_flags));

  assert_setf_dp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_set_flags) |-> out_class == 2'd0);

  assert_link_br_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_link) |-> out_class == 2'd2);

  assert_branch_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[27:25] == 3'b101) |=> out_class == 2'd2);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_class)
                                   && $stable(out_exec)));

  assert_ready_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind dcu_top dcu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_instr      (in_instr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_class     (out_class),
  .out_exec      (out_exec),
  .out_wr_en     (out_wr_en),
  .out_set_flags (out_set_flags),
  .out_link      (out_link),
  .out_target    (out_target)
);

// File: tb/dcu_top_tb.sv
module dcu_top_tb;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_instr = '0;
  logic [ADDR_W-1:0] in_pc = '0;
  logic [3:0] in_flags = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_class;
  logic [3:0] out_opcode, out_rn, out_rd;
  logic out_imm_sel, out_exec, out_wr_en, out_set_flags, out_link;
  logic [ADDR_W-1:0] out_link_addr, out_target;

  always #5 clk = ~clk;

  dcu_top #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_opcode(out_opcode), .out_rn(out_rn), .out_rd(out_rd),
    .out_imm_sel(out_imm_sel), .out_exec(out_exec), .out_wr_en(out_wr_en),
    .out_set_flags(out_set_flags), .out_link(out_link),
    .out_link_addr(out_link_addr), .out_target(out_target)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // {instr, pc, flags NZCV, class, exec, wr, link, setf}
  localparam int NV = 29;
  localparam logic [73:0] VEC [NV] = '{
    {32'hE3520000, 32'h00400000, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'hE3A00000, 32'h00400004, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hD1A0F00E, 32'h00400008, 4'b0100, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hD1A0F00E, 32'h00400008, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hE2522001, 32'h0040000C, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'hE0800001, 32'h00400010, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hEAFFFFFB, 32'h00400018, 4'b0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hEBFFFFFB, 32'h00400018, 4'b0000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0BFFFFFB, 32'h00400018, 4'b0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0BFFFFFB, 32'h00400018, 4'b0100, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'hE5920000, 32'h00400020, 4'b0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hE5820000, 32'h00400024, 4'b0000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hF3A00000, 32'h00000000, 4'b1111, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hE8000000, 32'h00000000, 4'b0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hEE000000, 32'h00000000, 4'b0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h83A00000, 32'h00000000, 4'b0010, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h93A00000, 32'h00000000, 4'b0010, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hA3A00000, 32'h00000000, 4'b1001, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hB3A00000, 32'h00000000, 4'b1001, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hC3A00000, 32'h00000000, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h13A00000, 32'h00000000, 4'b0100, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h63A00000, 32'h00000000, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h43A00000, 32'h00000000, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hE1500001, 32'h00001000, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'hE3B00000, 32'h00001004, 4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'hE4900004, 32'h00001008, 4'b0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hE6000000, 32'h0000100C, 4'b0000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hD3B00000, 32'h00001010, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h5AFFFFFF, 32'hFFFFFFF0, 4'b1000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  // Expected condition result, written from R3, R4 and R5.
  function automatic bit exp_pass(input logic [3:0] cc, input logic [3:0] fl);
    bit n, z, c, v;
    {n, z, c, v} = fl;
    case (cc)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return c;
      4'd3: return !c;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return v;
      4'd7: return !v;
      4'd8: return c & !z;
      4'd9: return !c | z;
      4'd10: return n ~^ v;
      4'd11: return n ^ v;
      4'd12: return !z & (n ~^ v);
      4'd13: return z | (n ^ v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [31:0] w);
    int signed off;
    off = int'(signed'(w[23:0])) * 4;
    return pc + 32'd8 + 32'(off);
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] pc, input logic [3:0] fl);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_pc = pc; in_flags = fl; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid == 1'b0, "R12 out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R12 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 out_valid after reset", 64'(out_valid), 64'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w, pc;
      logic [3:0] fl;
      logic [5:0] exp_res;
      {w, pc, fl, exp_res} = VEC[i];
      send(w, pc, fl);
      chk(out_valid == 1'b1, "R11 result valid one cycle after take", 64'(out_valid), 64'd1);
      chk({out_class, out_exec, out_wr_en, out_link, out_set_flags} == exp_res,
          $sformatf("R1 R5 R7 R8 R9 R10 class/exec/wr/link/setf vec %0d", i),
          64'({out_class, out_exec, out_wr_en, out_link, out_set_flags}), 64'(exp_res));
      chk({out_opcode, out_rn, out_rd} == {w[24:21], w[19:16], w[15:12]},
          $sformatf("R2 fields vec %0d", i),
          64'({out_opcode, out_rn, out_rd}), 64'({w[24:21], w[19:16], w[15:12]}));
      chk(out_imm_sel == ((exp_res[5:4] == 2'd0) && w[25]),
          $sformatf("R2 imm_sel vec %0d", i), 64'(out_imm_sel),
          64'((exp_res[5:4] == 2'd0) && w[25]));
      chk(out_target == exp_target(pc, w), $sformatf("R6 target vec %0d", i),
          64'(out_target), 64'(exp_target(pc, w)));
      chk(out_link_addr == pc + 32'd4, $sformatf("R7 link_addr vec %0d", i),
          64'(out_link_addr), 64'(pc + 32'd4));
    end

    // R6 worked example
    send(32'hEAFFFFFB, 32'h00400018, 4'b0000);
    chk(out_target == 32'h0040000C, "R6 example target", 64'(out_target), 64'h0040000C);

    // R3 R4 R5: all codes against all flag sets, data-processing move
    for (int cc = 0; cc < 16; cc++) begin
      for (int fl = 0; fl < 16; fl++) begin
        bit p;
        p = exp_pass(4'(cc), 4'(fl));
        send({4'(cc), 28'h3A00000}, 32'h0, 4'(fl));
        chk({out_exec, out_wr_en} == {p, p},
            $sformatf("R3 R4 R5 cond %0d flags %0h", cc, fl),
            64'({out_exec, out_wr_en}), 64'({p, p}));
      end
    end

    // R11: back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_instr = 32'hEBFFFFFB; in_pc = 32'h00002000; in_flags = 4'b0000;
    @(negedge clk);
    chk(in_ready == 1'b0, "R11 in_ready low while stalled", 64'(in_ready), 64'd0);
    in_instr = 32'hE8000000; in_pc = 32'h00003000;
    @(negedge clk);
    chk(out_valid && out_target == exp_target(32'h00002000, 32'hEBFFFFFB) && out_link,
        "R11 stalled result held", 64'(out_target), 64'(exp_target(32'h00002000, 32'hEBFFFFFB)));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_class == 2'd3, "R11 waiting word taken on release",
        64'(out_class), 64'd3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 drained", 64'(out_valid), 64'd0);

    done = 1;
    summary();
  end
endmodule